// File: doc/BRIEF.md
# Polyphase Interpolating FIR Filter

This block raises the rate of a stream of signed samples by a fixed factor L (five by default). The low-pass prototype tap set is split into L phase sub-filters. Sub-filter k holds prototype taps k, k+L, k+2L and so on. Every sub-filter sees the same sample window: the newest accepted sample and the same history. Each one yields one of the L points that belong between that sample and the next. All sub-filters have the same latency, so the L results are captured on one clock edge. A serializer then presents them one per enabled cycle as phases 0 through L-1.

A sample is taken when its valid strobe and the clock enable are both high. To keep a continuous high-rate output, the source supplies one sample every L enabled cycles. The result is the same as inserting L-1 zeros after each input sample and convolving the padded stream with the whole prototype. The polyphase split only avoids multiplying by the inserted zeros. Products are summed at full precision. The sum is then fitted into the signed output word: the output LSB carries the same weight as a product LSB, and the value saturates when it does not fit.

Top module: `poly_interp_fir`

## Requirements
- R1: The clock edge that accepts a sample raises `out_valid` with `out_phase` = 0. Each later enabled cycle shows the next phase, up to L-1 (4 by default). After the enabled cycle that shows phase L-1, `out_valid` falls unless a new sample is accepted on that edge.
- R2: For accepted samples x[0], x[1], ... the output shown with phase k for sample n equals y[L·n+k] = Σ h[i]·z[L·n+k−i]. Here z is the input stream with L−1 zeros inserted after each sample, h is the full prototype, and terms before the first sample count as zero.
- R3: Phase k uses only taps h[k], h[k+L], h[k+2L], .... An impulse of amplitude a, followed by zeros, makes phase k of the j-th sample after the impulse equal a·h[k+L·j].
- R4: A sample is accepted only on an edge where both `in_valid` and `ce` are 1. With either one low, the history and the outputs do not change.
- R5: While `ce` is 0, `out_valid`, `out_phase` and `out_data` hold their values.
- R6: Synchronous active-high `rst` clears `out_valid` and sets every stored past sample to zero, so samples taken before reset do not contribute to outputs after it.
- R7: Each sub-filter sums its products exactly. `out_data` is a two's-complement word of OUT_W bits (32) whose LSB weight is the product LSB. With integer input and Q1.15 taps the output is in 17.15 format. A sum above the largest or below the smallest OUT_W-bit value is clamped to that limit.
- R8: A sample accepted while phases of the previous one are still pending restarts the output at phase 0 with the new results. The phases not yet shown are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; gates every state change |
| in_valid | input | 1 | New-sample strobe |
| in_data | input | IN_W (16) | Signed input sample |
| out_valid | output | 1 | A phase output is presented |
| out_phase | output | $clog2(L) (3) | Index of the presented phase |
| out_data | output | OUT_W (32) | Signed interpolated output |

## Verification
The bench builds a 20-tap configuration. Phase 0 has every tap at full negative scale and the other taps are mixed. Single impulses of several amplitudes map each output back to one prototype tap, which separates a wrong tap split (R3) from a wrong sum. A pseudo-random stream with no gaps checks the zero-stuffed convolution model (R2). Runs of extreme samples push phase 0 past both ends of the output range while the other phases stay in range (R7). Directed sequences cover the remaining rules: enable gaps with a junk strobe present, an early second sample, and a reset in the middle of a stream. Each of these tells a frozen or ignored input apart from one that leaks into the history or the phase counter.

// File: rtl/poly_interp_pkg.sv
`timescale 1ns/1ps
package poly_interp_pkg;
   localparam int DEF_L      = 5;
   localparam int DEF_TAPS   = 10;
   localparam int DEF_COEF_W = 16;

   // Triangular kernel (linear interpolation) in Q1.15, padded to a multiple of L
   function automatic logic [DEF_TAPS*DEF_COEF_W-1:0] tri_coefs();
      logic [DEF_TAPS*DEF_COEF_W-1:0] v;
      v = '0;
      for (int i = 0; i < DEF_TAPS; i++) begin
         int w;
         w = (i < DEF_L) ? (i + 1) : (2*DEF_L - 1 - i);
         v[i*DEF_COEF_W +: DEF_COEF_W] = DEF_COEF_W'((w * 32767) / DEF_L);
      end
      return v;
   endfunction
endpackage

// File: rtl/pif_history.sv
`timescale 1ns/1ps
module pif_history #(
   parameter int IN_W  = 16,
   parameter int DEPTH = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   adv,
   input  logic signed [IN_W-1:0] din,
   output logic signed [IN_W-1:0] win [DEPTH]
);
   assign win[0] = din;

   generate
      if (DEPTH > 1) begin : g_hist
         logic signed [IN_W-1:0] past [DEPTH-1];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH-1; i++) past[i] <= '0;
            end else if (adv) begin
               past[0] <= din;
               for (int i = 1; i < DEPTH-1; i++) past[i] <= past[i-1];
            end
         end
         for (genvar j = 1; j < DEPTH; j++) begin : g_tap
            assign win[j] = past[j-1];
         end
      end
   endgenerate
endmodule

// File: rtl/pif_subfilter.sv
`timescale 1ns/1ps
module pif_subfilter #(
   parameter int IN_W   = 16,
   parameter int COEF_W = 16,
   parameter int OUT_W  = 32,
   parameter int L      = 5,
   parameter int TAPS   = 10,
   parameter int PHASE  = 0,
   parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic signed [IN_W-1:0]  win [TAPS/L],
   output logic signed [OUT_W-1:0] res
);
   localparam int SUB_TAPS = TAPS / L;
   localparam int PROD_W   = IN_W + COEF_W;
   localparam int ACC_W    = PROD_W + $clog2(SUB_TAPS);

   logic signed [ACC_W-1:0] acc;
   logic signed [OUT_W-1:0] fmt;

   always_comb begin
      logic signed [PROD_W-1:0] prod;
      acc = '0;
      for (int j = 0; j < SUB_TAPS; j++) begin
         prod = win[j] * $signed(COEFS[(PHASE + L*j)*COEF_W +: COEF_W]);
         acc  = acc + ACC_W'(prod);
      end
   end

   generate
      if (OUT_W >= ACC_W) begin : g_extend
         assign fmt = OUT_W'(acc);
      end else begin : g_clamp
         logic [ACC_W-OUT_W:0] top;
         logic                 fits;
         assign top  = acc[ACC_W-1:OUT_W-1];
         assign fits = (&top) | ~(|top);
         always_comb begin
            if (fits)              fmt = acc[OUT_W-1:0];
            else if (acc[ACC_W-1]) fmt = {1'b1, {(OUT_W-1){1'b0}}};
            else                   fmt = {1'b0, {(OUT_W-1){1'b1}}};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       res <= '0;
      else if (load) res <= fmt;
   end
endmodule

// File: rtl/pif_serializer.sv
`timescale 1ns/1ps
module pif_serializer #(
   parameter int OUT_W = 32,
   parameter int L     = 5,
   parameter int PH_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ce,
   input  logic                    start,
   input  logic signed [OUT_W-1:0] res [L],
   output logic                    out_valid,
   output logic [PH_W-1:0]         out_phase,
   output logic signed [OUT_W-1:0] out_data
);
   logic            busy;
   logic [PH_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (ce) begin
         if (start) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (busy) begin
            if (idx == PH_W'(L-1)) begin
               busy <= 1'b0;
               idx  <= '0;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign out_valid = busy;
   assign out_phase = idx;
   assign out_data  = res[idx];
endmodule

// File: rtl/poly_interp_fir.sv
`timescale 1ns/1ps
module poly_interp_fir #(
   parameter int IN_W   = 16,
   parameter int COEF_W = poly_interp_pkg::DEF_COEF_W,
   parameter int OUT_W  = 32,
   parameter int L      = poly_interp_pkg::DEF_L,
   parameter int TAPS   = poly_interp_pkg::DEF_TAPS,
   parameter logic [TAPS*COEF_W-1:0] COEFS = poly_interp_pkg::tri_coefs(),
   localparam int PH_W  = $clog2(L)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ce,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_data,
   output logic                    out_valid,
   output logic [PH_W-1:0]         out_phase,
   output logic signed [OUT_W-1:0] out_data
);
   localparam int SUB_TAPS = TAPS / L;

   generate
      if (L < 2)            begin : g_bad_l    $error("interpolation factor must be at least 2"); end
      if (TAPS % L != 0)    begin : g_bad_taps $error("tap count must be a multiple of the factor"); end
      if (OUT_W < 2 || IN_W < 2 || COEF_W < 2) begin : g_bad_w $error("widths must be at least 2"); end
   endgenerate

   logic                    take;
   logic signed [IN_W-1:0]  win [SUB_TAPS];
   logic signed [OUT_W-1:0] res [L];

   assign take = ce & in_valid;

   pif_history #(.IN_W(IN_W), .DEPTH(SUB_TAPS)) hist_i (
      .clk(clk), .rst(rst), .adv(take), .din(in_data), .win(win)
   );

   generate
      for (genvar k = 0; k < L; k++) begin : g_phase
         pif_subfilter #(
            .IN_W(IN_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
            .L(L), .TAPS(TAPS), .PHASE(k), .COEFS(COEFS)
         ) sub_i (
            .clk(clk), .rst(rst), .load(take), .win(win), .res(res[k])
         );
      end
   endgenerate

   pif_serializer #(.OUT_W(OUT_W), .L(L), .PH_W(PH_W)) ser_i (
      .clk(clk), .rst(rst), .ce(ce), .start(take), .res(res),
      .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
   );
endmodule

// File: rtl/poly_interp_fir_chk.sv
`timescale 1ns/1ps
module poly_interp_fir_chk #(
   parameter int OUT_W = 32,
   parameter int L     = 5,
   parameter int PH_W  = 3
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    ce,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic [PH_W-1:0]         out_phase,
   input logic signed [OUT_W-1:0] out_data
);
   p_reset_idle_r6: assert property (@(posedge clk) rst |=> !out_valid);

   p_first_phase_r1: assert property (@(posedge clk) disable iff (rst)
      (ce && in_valid) |=> (out_valid && out_phase == '0));

   p_restart_r8: assert property (@(posedge clk) disable iff (rst)
      (ce && in_valid && out_valid) |=> (out_phase == '0));

   p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
      (ce && !in_valid && out_valid && int'(out_phase) < L-1)
      |=> (out_valid && int'(out_phase) == int'($past(out_phase)) + 1));

   p_burst_end_r1: assert property (@(posedge clk) disable iff (rst)
      (ce && !in_valid && out_valid && int'(out_phase) == L-1) |=> !out_valid);

   p_phase_range_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> int'(out_phase) < L);

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!(ce && in_valid) && !out_valid) |=> !out_valid);

   p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(out_valid) && $stable(out_phase) && $stable(out_data)));
endmodule

bind poly_interp_fir poly_interp_fir_chk #(.OUT_W(OUT_W), .L(L), .PH_W(PH_W)) chk_i (
   .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid),
   .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
);

// File: tb/poly_interp_fir_tb_top.sv
`timescale 1ns/1ps
module poly_interp_fir_tb_top;
   localparam int IN_W = 16, COEF_W = 16, OUT_W = 32, L = 5, TAPS = 20;

   function automatic int tap(int i);
      if (i % L == 0) return -32768;
      return ((i * 7919) % 20001) - 10000;
   endfunction

   function automatic logic [TAPS*COEF_W-1:0] pack_taps();
      logic [TAPS*COEF_W-1:0] v;
      v = '0;
      for (int i = 0; i < TAPS; i++) v[i*COEF_W +: COEF_W] = COEF_W'(tap(i));
      return v;
   endfunction

   localparam logic [TAPS*COEF_W-1:0] TB_COEFS = pack_taps();

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    ce = 1'b0;
   logic                    in_valid = 1'b0;
   logic signed [IN_W-1:0]  in_data = '0;
   logic                    out_valid;
   logic [2:0]              out_phase;
   logic signed [OUT_W-1:0] out_data;

   poly_interp_fir #(.IN_W(IN_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .L(L),
                     .TAPS(TAPS), .COEFS(TB_COEFS)) dut_i (
      .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
   );

   always #4 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   int xs [512];
   int cnt = 0;
   logic [15:0] lfsr = 16'hACE1;

   // Zero-stuffed stream convolved with the whole prototype, then clamped
   function automatic longint ref_val(int n, int k);
      longint acc = 0;
      for (int i = 0; i < TAPS; i++) begin
         int t = L*n + k - i;
         if (t >= 0 && t % L == 0) acc += longint'(tap(i)) * longint'(xs[t/L]);
      end
      if (acc > 64'sd2147483647)  acc = 64'sd2147483647;
      if (acc < -64'sd2147483648) acc = -64'sd2147483648;
      return acc;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check_ph(int k, string req);
      longint e = ref_val(cnt-1, k);
      n_cmp++;
      if (out_valid !== 1'b1 || int'(out_phase) != k || longint'(out_data) != e) begin
         n_bad++;
         $display("FAIL %s: valid=%0b phase=%0d data=%0d, expected valid=1 phase=%0d data=%0d",
                  req, out_valid, out_phase, out_data, k, e);
      end
   endtask

   task automatic check_idle(string req);
      n_cmp++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: out_valid=%0b, expected 0", req, out_valid);
      end
   endtask

   task automatic accept(int x);
      ce = 1'b1; in_valid = 1'b1; in_data = IN_W'(x);
      tick();
      in_valid = 1'b0;
      xs[cnt] = x;
      cnt++;
   endtask

   task automatic burst(int x, bit tail, string req);
      accept(x);
      for (int k = 0; k < L; k++) begin
         check_ph(k, req);
         if (k < L-1) tick();
      end
      if (tail) begin
         tick();
         check_idle(req);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; ce = 1'b1; in_valid = 1'b0;
      tick(); tick();
      check_idle("R6");
      rst = 1'b0;
      cnt = 0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      check_idle("R6");
      rst = 1'b0; ce = 1'b1;

      // R4: idle cycles with strobe low produce nothing
      repeat (3) begin tick(); check_idle("R4"); end

      // R3: impulses of several amplitudes expose each tap
      foreach (xs[i]) xs[i] = 0;
      for (int a = 0; a < 3; a++) begin
         int amp = (a == 0) ? 1 : (a == 1) ? -1 : 12345;
         do_reset();
         burst(amp, 1'b0, "R3");
         for (int z = 0; z < TAPS/L - 1; z++) burst(0, 1'b0, "R3");
         tick(); check_idle("R1");
      end

      // R2: continuous pseudo-random stream
      do_reset();
      for (int s = 0; s < 40; s++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         burst(int'($signed(lfsr)), (s == 39), "R2");
      end

      // R5 and R4: enable gap with a junk strobe present
      burst(2000, 1'b0, "R2");
      accept(-777);
      check_ph(0, "R1"); tick();
      check_ph(1, "R1");
      ce = 1'b0; in_valid = 1'b1; in_data = 16'sh7ABC;
      repeat (3) begin tick(); check_ph(1, "R5"); end
      ce = 1'b1; in_valid = 1'b0;
      for (int k = 2; k < L; k++) begin tick(); check_ph(k, "R5"); end
      tick(); check_idle("R1");
      burst(31000, 1'b1, "R4");

      // R8: early sample restarts the phase sequence
      accept(4321);
      check_ph(0, "R8"); tick();
      check_ph(1, "R8");
      burst(-9876, 1'b1, "R8");

      // R7: drive phase 0 past both ends of the output range
      do_reset();
      for (int s = 0; s < 4; s++) burst(-32768, 1'b0, "R7");
      for (int s = 0; s < 4; s++) burst(32767, 1'b0, "R7");
      burst(32767, 1'b1, "R7");

      // R6: reset mid-stream clears history
      for (int s = 0; s < 2; s++) burst(30000, 1'b0, "R6");
      do_reset();
      burst(0, 1'b0, "R6");
      burst(1, 1'b1, "R6");

      finish_run();
   end
endmodule